// File: doc/BRIEF.md
# Accumulator Stack Machine Core

This block is a small sequential processor. It fetches fixed 32-bit instruction words from a synchronous instruction memory and runs them against one accumulator, a 16-entry hardware stack, a file of 16 data registers and a pseudo-random source. The program counter is a byte address. Every instruction fills one aligned 4-byte slot, so the counter steps by 4. Arithmetic and logic opcodes go to a separate combinational accumulator ALU.

Each instruction takes two clock cycles. In FETCH the counter drives the memory address. In EXEC the returned word is decoded and retired. The state machine has four states: FETCH, EXEC, YIELD and HALT. It has six named transitions:

- *issue*: FETCH to EXEC, always.
- *retire*: EXEC to FETCH.
- *suspend*: EXEC to YIELD, on a yield opcode.
- *trap*: EXEC to HALT, on any fault.
- *wake*: YIELD to FETCH, when `resume` is high.
- *park*: HALT stays in HALT until reset.

An external controller watches `yielded` and `err_flag`. It restarts a yielded program with a one-cycle `resume` pulse. The accumulator is visible on `acc_out`.

Top module: `acc_core`

## Requirements
- R1: After reset the counter is 0, both flags are low and the accumulator is 0. Each retired instruction that is not a taken jump advances the counter by 4. An instruction spends one cycle in FETCH and one in EXEC.
- R2: The word layout is opcode in bits 31:24, operand type in bits 23:16 and a signed value in bits 15:0. Type 0 selects the sign-extended value as an immediate. Type 1 selects data register value[3:0]. For opcodes 3 to 20 and 22, any type above 1 traps.
- R3: Opcode 1 jumps to the sign-extended value. Opcode 2 jumps there only when the accumulator is nonzero; otherwise it advances by 4.
- R4: A taken jump whose target has nonzero bits 1:0 traps, and the counter stays on the jump.
- R5: Opcode 5 loads the operand into the accumulator. Opcode 6 with type 1 copies the accumulator into the selected register.
- R6: Opcode 3 pushes the operand. Opcode 4 pops the top entry, in LIFO order, into the selected register for type 1, or discards it for type 0.
- R7: Pushing onto a full 16-entry stack, or popping an empty one, traps, and the counter stays on that instruction.
- R8: Opcodes 7 to 20 write the accumulator A with B as the operand. The operations, in opcode order, are: A+B, A-B, low half of A*B, unsigned A/B, unsigned A%B, A<<B, logical A>>B, A&B, A|B, A^B, signed A<B, signed A>B, A==B, and ~B. The three comparisons give 1 or 0.
- R9: Division by zero gives all ones. Remainder by zero leaves A unchanged. Shifts use only bits 3:0 of the operand.
- R10: Opcode 22 writes the current random value into the accumulator (type 0) or the selected register (type 1), then steps the generator. The generator starts at 0xACE1. Each step shifts right and enters bit0^bit2^bit3^bit5 at bit 15.
- R11: Opcode 21 is a label. Apart from advancing the counter by 4, it changes no state.
- R12: Opcode 23 raises `yielded` with the counter on the next instruction. Both hold until a `resume` pulse, after which the core fetches again.
- R13: Opcode 0 and opcodes 24 to 255 trap. A trap raises `err_flag` and freezes the counter and accumulator until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 16 | Byte address of the instruction to fetch (the program counter) |
| imem_rdata | input | 32 | Instruction word, returned one cycle after the address |
| resume | input | 1 | One-cycle pulse that wakes a yielded core |
| yielded | output | 1 | Core is suspended in YIELD |
| err_flag | output | 1 | Core has trapped and sits in HALT |
| acc_out | output | 16 | Accumulator value |

## Verification
The bench targets the stack edges: a seventeenth push and a pop on an empty stack. A core that miscounted would wrap the stack pointer and carry on, or would trap one entry early. Misaligned jump targets and bad operand types are also driven. A core that ignored them would fetch from a torn slot or would read a register with a garbage index. Division and remainder by zero, shift amounts above 15, and a backward conditional loop that falls through at zero are all covered. These would show as a wrong accumulator or a wrong loop count. Yield is held for several cycles before `resume` arrives, which catches a core that restarts on its own or drifts its counter while suspended.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_EXEC  = 2'd1,
        S_YIELD = 2'd2,
        S_HALT  = 2'd3
    } core_state_t;

    localparam logic [7:0] OP_BAD   = 8'd0;
    localparam logic [7:0] OP_JMP   = 8'd1;
    localparam logic [7:0] OP_JNZ   = 8'd2;
    localparam logic [7:0] OP_PUSH  = 8'd3;
    localparam logic [7:0] OP_POP   = 8'd4;
    localparam logic [7:0] OP_LOAD  = 8'd5;
    localparam logic [7:0] OP_MOV   = 8'd6;
    localparam logic [7:0] OP_ADD   = 8'd7;
    localparam logic [7:0] OP_SUB   = 8'd8;
    localparam logic [7:0] OP_MUL   = 8'd9;
    localparam logic [7:0] OP_DIV   = 8'd10;
    localparam logic [7:0] OP_MOD   = 8'd11;
    localparam logic [7:0] OP_SHL   = 8'd12;
    localparam logic [7:0] OP_SHR   = 8'd13;
    localparam logic [7:0] OP_AND   = 8'd14;
    localparam logic [7:0] OP_OR    = 8'd15;
    localparam logic [7:0] OP_XOR   = 8'd16;
    localparam logic [7:0] OP_LT    = 8'd17;
    localparam logic [7:0] OP_GT    = 8'd18;
    localparam logic [7:0] OP_EQ    = 8'd19;
    localparam logic [7:0] OP_INV   = 8'd20;
    localparam logic [7:0] OP_LABEL = 8'd21;
    localparam logic [7:0] OP_RAND  = 8'd22;
    localparam logic [7:0] OP_YIELD = 8'd23;

    localparam logic [7:0] TY_IMM = 8'd0;
    localparam logic [7:0] TY_REG = 8'd1;

    localparam int INSN_BYTES = 4;
    localparam int INSN_W     = 32;
    localparam int VALUE_W    = 16;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int             DW   = 16,
    parameter logic [DW-1:0]  SEED = 'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          rand_step,
    output logic [DW-1:0] res
);
    import acc_pkg::*;

    localparam int SHW = $clog2(DW);

    logic [DW-1:0]  lfsr;
    logic [SHW-1:0] sh;

    assign sh = b[SHW-1:0];

    // Pseudo-random source: right shift, feedback enters at the top bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SEED;
        end else if (rand_step) begin
            lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[DW-1:1]};
        end
    end

    always_comb begin
        res = a;
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = a * b;
            OP_DIV:  res = (b == '0) ? '1 : a / b;
            OP_MOD:  res = (b == '0) ? a : a % b;
            OP_SHL:  res = a << sh;
            OP_SHR:  res = a >> sh;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_LT:   res = DW'($signed(a) < $signed(b));
            OP_GT:   res = DW'($signed(a) > $signed(b));
            OP_EQ:   res = DW'(a == b);
            OP_INV:  res = ~b;
            OP_RAND: res = lfsr;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/acc_stack.sv
module acc_stack #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] top,
    output logic          full,
    output logic          empty
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IW  = $clog2(DEPTH);

    logic [DW-1:0]  store [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_dec;

    assign sp_dec = sp - 1'b1;
    assign full   = (sp == SPW'(DEPTH));
    assign empty  = (sp == '0);
    assign top    = store[IW'(sp_dec)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + 1'b1;
        end else if (pop && !empty) begin
            sp <= sp_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            store[IW'(sp)] <= wdata;
        end
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    assign rdata = regs[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core #(
    parameter int DW          = 16,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 16,
    parameter int NREG        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    input  logic            resume,
    output logic            yielded,
    output logic            err_flag,
    output logic [DW-1:0]   acc_out
);
    import acc_pkg::*;

    localparam int RAW = $clog2(NREG);

    core_state_t state, state_nxt;

    logic [PC_W-1:0] pc, pc_nxt, tgt;
    logic [DW-1:0]   acc, acc_nxt;

    logic [7:0]         ins_op, ins_ty;
    logic [VALUE_W-1:0] ins_val;
    logic [DW-1:0]      imm, opnd;
    logic               uses_opnd, type_bad, tgt_bad;

    logic            rf_we;
    logic [DW-1:0]   rf_wdata, rf_rdata;
    logic            st_push, st_pop, st_full, st_empty;
    logic [DW-1:0]   st_top;
    logic            rand_step;
    logic [DW-1:0]   alu_res;
    logic            fault, yield_go;

    // Field split
    assign ins_op  = imem_rdata[31:24];
    assign ins_ty  = imem_rdata[23:16];
    assign ins_val = imem_rdata[15:0];

    assign imm  = DW'($signed(ins_val));
    assign tgt  = PC_W'($signed(ins_val));
    assign opnd = (ins_ty == TY_REG) ? rf_rdata : imm;

    assign tgt_bad   = |tgt[1:0];
    assign uses_opnd = ((ins_op >= OP_PUSH) && (ins_op <= OP_INV)) || (ins_op == OP_RAND);
    assign type_bad  = uses_opnd && (ins_ty > TY_REG);

    acc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (ins_val[RAW-1:0]),
        .wdata (rf_wdata),
        .raddr (ins_val[RAW-1:0]),
        .rdata (rf_rdata)
    );

    acc_stack #(.DW(DW), .DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (st_push),
        .pop   (st_pop),
        .wdata (opnd),
        .top   (st_top),
        .full  (st_full),
        .empty (st_empty)
    );

    acc_alu #(.DW(DW)) u_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (ins_op),
        .a         (acc),
        .b         (opnd),
        .rand_step (rand_step),
        .res       (alu_res)
    );

    // Execute decode: side effects only in EXEC and only without a fault
    always_comb begin
        pc_nxt    = pc + PC_W'(INSN_BYTES);
        acc_nxt   = acc;
        rf_we     = 1'b0;
        rf_wdata  = acc;
        st_push   = 1'b0;
        st_pop    = 1'b0;
        rand_step = 1'b0;
        fault     = 1'b0;
        yield_go  = 1'b0;
        if (state == S_EXEC) begin
            if (type_bad) begin
                fault = 1'b1;
            end else begin
                case (ins_op)
                    OP_JMP: begin
                        if (tgt_bad) fault = 1'b1;
                        else         pc_nxt = tgt;
                    end
                    OP_JNZ: begin
                        if (acc != '0) begin
                            if (tgt_bad) fault = 1'b1;
                            else         pc_nxt = tgt;
                        end
                    end
                    OP_PUSH: begin
                        if (st_full) fault = 1'b1;
                        else         st_push = 1'b1;
                    end
                    OP_POP: begin
                        if (st_empty) begin
                            fault = 1'b1;
                        end else begin
                            st_pop   = 1'b1;
                            rf_we    = (ins_ty == TY_REG);
                            rf_wdata = st_top;
                        end
                    end
                    OP_LOAD:  acc_nxt = opnd;
                    OP_MOV:   rf_we   = (ins_ty == TY_REG);
                    OP_LABEL: ;
                    OP_RAND: begin
                        rand_step = 1'b1;
                        rf_wdata  = alu_res;
                        if (ins_ty == TY_REG) rf_we   = 1'b1;
                        else                  acc_nxt = alu_res;
                    end
                    OP_YIELD: yield_go = 1'b1;
                    default: begin
                        if ((ins_op >= OP_ADD) && (ins_op <= OP_INV)) acc_nxt = alu_res;
                        else                                           fault   = 1'b1;
                    end
                endcase
            end
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_FETCH: state_nxt = S_EXEC;
            S_EXEC: begin
                if (fault)         state_nxt = S_HALT;
                else if (yield_go) state_nxt = S_YIELD;
                else               state_nxt = S_FETCH;
            end
            S_YIELD: if (resume) state_nxt = S_FETCH;
            S_HALT:  state_nxt = S_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nxt;
    end

    // Architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            acc <= '0;
        end else if ((state == S_EXEC) && !fault) begin
            pc  <= pc_nxt;
            acc <= acc_nxt;
        end
    end

    // Outputs
    always_comb begin
        imem_addr = pc;
        acc_out   = acc;
        yielded   = (state == S_YIELD);
        err_flag  = (state == S_HALT);
    end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int DW   = 16,
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic            resume,
    input logic            yielded,
    input logic            err_flag,
    input logic [DW-1:0]   acc_out
);
    // R1: the fetch address always sits on a slot boundary
    p_pc_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);

    // R13: a trap is permanent and freezes the architectural state
    p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag && $stable(imem_addr) && $stable(acc_out));

    // R12: without resume the core stays suspended at the same address
    p_yield_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (yielded && !resume) |=> (yielded && $stable(imem_addr) && $stable(acc_out)));

    // R12: a resume pulse wakes the core on the next cycle
    p_yield_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (yielded && resume) |=> !yielded);

    // R12: suspended and trapped never coincide
    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(yielded && err_flag));

endmodule

bind acc_core acc_core_chk #(.DW(DW), .PC_W(PC_W)) u_acc_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .resume    (resume),
    .yielded   (yielded),
    .err_flag  (err_flag),
    .acc_out   (acc_out)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resume = 1'b0;
    logic [15:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        yielded, err_flag;
    logic [15:0] acc_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem [64];

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .resume     (resume),
        .yielded    (yielded),
        .err_flag   (err_flag),
        .acc_out    (acc_out)
    );

    always @(posedge clk) imem_rdata <= mem[imem_addr[7:2]];

    // ---------------- reference model ----------------
    int          m_st;     // 0 fetch, 1 exec, 2 yield, 3 halt
    logic [15:0] m_pc, m_acc, m_lfsr;
    logic [15:0] m_reg [16];
    logic [15:0] m_stk [$];

    function automatic logic [15:0] alu_ref(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        case (op)
            8'd7:  r = a + b;
            8'd8:  r = a - b;
            8'd9:  r = a * b;
            8'd10: r = (b == 0) ? 16'hFFFF : a / b;
            8'd11: r = (b == 0) ? a : a % b;
            8'd12: r = a << b[3:0];
            8'd13: r = a >> b[3:0];
            8'd14: r = a & b;
            8'd15: r = a | b;
            8'd16: r = a ^ b;
            8'd17: r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
            8'd18: r = ($signed(a) > $signed(b)) ? 16'd1 : 16'd0;
            8'd19: r = (a == b) ? 16'd1 : 16'd0;
            default: r = ~b;
        endcase
        return r;
    endfunction

    function automatic void model_exec();
        logic [31:0] w;
        logic [7:0]  op, ty;
        logic [15:0] val, opd, npc;
        int          nst;
        bit          bad;
        w   = mem[m_pc[7:2]];
        op  = w[31:24];
        ty  = w[23:16];
        val = w[15:0];
        opd = (ty == 8'd1) ? m_reg[val[3:0]] : val;
        npc = m_pc + 16'd4;
        nst = 0;
        bad = 0;
        if ((((op >= 3) && (op <= 20)) || (op == 22)) && (ty > 1)) bad = 1;
        else begin
            case (op)
                8'd1: if (val[1:0] != 0) bad = 1; else npc = val;
                8'd2: if (m_acc != 0) begin
                          if (val[1:0] != 0) bad = 1; else npc = val;
                      end
                8'd3: if (m_stk.size() == 16) bad = 1; else m_stk.push_back(opd);
                8'd4: if (m_stk.size() == 0) bad = 1;
                      else begin
                          logic [15:0] v;
                          v = m_stk.pop_back();
                          if (ty == 8'd1) m_reg[val[3:0]] = v;
                      end
                8'd5: m_acc = opd;
                8'd6: if (ty == 8'd1) m_reg[val[3:0]] = m_acc;
                8'd21: ;
                8'd22: begin
                    if (ty == 8'd1) m_reg[val[3:0]] = m_lfsr; else m_acc = m_lfsr;
                    m_lfsr = {m_lfsr[0] ^ m_lfsr[2] ^ m_lfsr[3] ^ m_lfsr[5], m_lfsr[15:1]};
                end
                8'd23: nst = 2;
                default: if ((op >= 7) && (op <= 20)) m_acc = alu_ref(op, m_acc, opd);
                         else bad = 1;
            endcase
        end
        if (bad) m_st = 3;
        else begin
            m_pc = npc;
            m_st = nst;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_acc = 0; m_lfsr = 16'hACE1;
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
            m_stk.delete();
        end else begin
            case (m_st)
                0: m_st = 1;
                1: model_exec();
                2: if (resume) m_st = 0;
                default: ;
            endcase
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 pc vs model", imem_addr, m_pc);
            chk("R5 acc vs model", acc_out, m_acc);
            chk("R13 err_flag vs model", err_flag, (m_st == 3));
            chk("R12 yielded vs model", yielded, (m_st == 2));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] ins(input logic [7:0] op, input logic [7:0] ty, input logic [15:0] val);
        return {op, ty, val};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (err_flag || yielded) break;
        end
    endtask

    initial begin
        // reset state
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", imem_addr, 0);
        chk("R1 reset acc", acc_out, 0);
        chk("R13 reset err", err_flag, 0);
        chk("R12 reset yielded", yielded, 0);

        // ALU program
        clear_mem();
        mem[0]  = ins(5, 0, 16'd7);
        mem[1]  = ins(7, 0, 16'd5);
        mem[2]  = ins(8, 0, 16'd2);
        mem[3]  = ins(9, 0, 16'hFFFD);
        mem[4]  = ins(6, 1, 16'd3);
        mem[5]  = ins(5, 0, 16'd100);
        mem[6]  = ins(10, 0, 16'd7);
        mem[7]  = ins(11, 0, 16'd4);
        mem[8]  = ins(12, 0, 16'd3);
        mem[9]  = ins(13, 0, 16'd2);
        mem[10] = ins(14, 0, 16'd6);
        mem[11] = ins(15, 0, 16'd1);
        mem[12] = ins(16, 0, 16'd15);
        mem[13] = ins(17, 0, 16'd11);
        mem[14] = ins(5, 1, 16'd3);
        mem[15] = ins(18, 0, 16'd0);
        mem[16] = ins(19, 0, 16'd0);
        mem[17] = ins(20, 0, 16'h00F0);
        do_reset();
        repeat (4) @(negedge clk);
        chk("R1 two cycles per insn", imem_addr, 8);
        repeat (5) @(negedge clk);
        chk("R8 mul by sign-extended -3 (R2)", acc_out, 16'hFFE2);
        wait_stop();
        chk("R8 final accumulator", acc_out, 16'hFF0F);
        chk("R13 opcode 0 trap pc", imem_addr, 72);
        chk("R13 opcode 0 raises err", err_flag, 1);

        // divide / remainder by zero, shift width
        clear_mem();
        mem[0] = ins(5, 0, 16'd9);
        mem[1] = ins(10, 0, 16'd0);
        mem[2] = ins(6, 1, 16'd1);
        mem[3] = ins(5, 0, 16'd9);
        mem[4] = ins(11, 0, 16'd0);
        mem[5] = ins(7, 1, 16'd1);
        mem[6] = ins(12, 0, 16'h0011);
        do_reset();
        repeat (4) @(negedge clk);
        chk("R9 div by zero all ones", acc_out, 16'hFFFF);
        wait_stop();
        chk("R9 mod by zero keeps, shift uses low 4 bits", acc_out, 16'd16);
        chk("R9 end pc", imem_addr, 28);

        // stack order, discard pop
        clear_mem();
        mem[0]  = ins(3, 0, 16'd1);
        mem[1]  = ins(3, 0, 16'd2);
        mem[2]  = ins(5, 0, 16'd5);
        mem[3]  = ins(6, 1, 16'd2);
        mem[4]  = ins(3, 1, 16'd2);
        mem[5]  = ins(5, 0, 16'd0);
        mem[6]  = ins(4, 1, 16'd4);
        mem[7]  = ins(4, 0, 16'd0);
        mem[8]  = ins(4, 1, 16'd5);
        mem[9]  = ins(5, 1, 16'd4);
        mem[10] = ins(7, 1, 16'd5);
        do_reset();
        wait_stop();
        chk("R6 LIFO pop and discard", acc_out, 16'd6);
        chk("R5 mov/load via register", imem_addr, 44);

        // overflow
        clear_mem();
        mem[0] = ins(3, 0, 16'd3);
        mem[1] = ins(1, 0, 16'd0);
        do_reset();
        wait_stop();
        chk("R7 push on full traps", err_flag, 1);
        chk("R7 push on full pc", imem_addr, 0);

        // underflow
        clear_mem();
        mem[0] = ins(3, 0, 16'd1);
        mem[1] = ins(4, 0, 16'd0);
        mem[2] = ins(4, 0, 16'd0);
        do_reset();
        wait_stop();
        chk("R7 pop on empty traps", err_flag, 1);
        chk("R7 pop on empty pc", imem_addr, 8);

        // branches and misaligned target
        clear_mem();
        mem[0] = ins(5, 0, 16'd3);
        mem[1] = ins(8, 0, 16'd1);
        mem[2] = ins(2, 0, 16'd4);
        mem[3] = ins(1, 0, 16'd20);
        mem[5] = ins(21, 0, 16'd0);
        mem[6] = ins(1, 0, 16'd30);
        do_reset();
        wait_stop();
        chk("R3 loop ran to zero", acc_out, 0);
        chk("R4 misaligned jump stays on jump", imem_addr, 24);
        chk("R4 misaligned jump traps", err_flag, 1);

        // random source
        clear_mem();
        mem[0] = ins(22, 0, 16'd0);
        mem[1] = ins(22, 1, 16'd7);
        mem[2] = ins(5, 1, 16'd7);
        do_reset();
        repeat (2) @(negedge clk);
        chk("R10 first random value", acc_out, 16'hACE1);
        wait_stop();
        chk("R10 second random value via register", acc_out, 16'h5670);

        // label no effect, bad opcode
        clear_mem();
        mem[0] = ins(21, 0, 16'd99);
        mem[1] = ins(8'd200, 0, 16'd0);
        do_reset();
        repeat (2) @(negedge clk);
        chk("R11 label advances pc", imem_addr, 4);
        chk("R11 label leaves acc", acc_out, 0);
        wait_stop();
        chk("R13 opcode 200 traps", err_flag, 1);
        chk("R13 opcode 200 pc", imem_addr, 4);

        // bad operand type
        clear_mem();
        mem[0] = ins(5, 2, 16'd5);
        do_reset();
        wait_stop();
        chk("R2 type 2 traps", err_flag, 1);
        chk("R2 type 2 leaves acc", acc_out, 0);

        // yield and resume
        clear_mem();
        mem[0] = ins(5, 0, 16'd42);
        mem[1] = ins(23, 0, 16'd0);
        mem[2] = ins(7, 0, 16'd1);
        do_reset();
        wait_stop();
        chk("R12 yielded raised", yielded, 1);
        chk("R12 pc on next insn", imem_addr, 8);
        repeat (10) @(negedge clk);
        chk("R12 still yielded", yielded, 1);
        chk("R12 pc held", imem_addr, 8);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        chk("R12 woke", yielded, 0);
        wait_stop();
        chk("R12 continued after resume", acc_out, 16'd43);
        chk("R12 end pc", imem_addr, 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule